// File: doc/BRIEF.md
# Two-Level Aperture Address Translator

This block maps addresses inside a graphics aperture window to physical addresses through a two-level table. The first level is a 64-slot directory kept in on-chip registers. Each slot covers 4 MiB of the aperture and points to a second-level page held in external memory. Each second-level page holds 1024 four-byte page entries. Software fills directory slots one at a time through a packed 32-bit register write. The same register write port also sets the aperture base, the aperture size code and a control register.

A translation request is taken with a ready/valid handshake. The block decides whether the address lies inside the configured window and whether its directory slot is present. If both hold, it first looks in a single-entry translation buffer. On a hit it answers in the next cycle. On a miss it issues one read on its memory port, checks the valid bit of the returned entry and answers. Only one translation is in flight at a time, and requests are held off while a fetch is pending.

Top module: `aper_xlate`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o is 0, mem_req_o is 0, the translation buffer is empty and every directory slot is not present.
- R2: A register write to offset 0xB8 loads one directory slot. Bits 5:0 give the slot, bit 8 the present flag and bits 31:12 the second-level page address. Bits 11:9 (attribute index) and bits 7:6 (reserved) have no effect on translation.
- R3: A write to offset 0xB8 whose present bit is 0 invalidates the selected slot, so later requests that land in that slot return a fault.
- R4: A request faults when it lies outside the aperture, when its slot is not present, or when its fetched entry has bit 0 clear. A fault gives rsp_fault_o=1 and rsp_paddr_o=0. A fault on range or on presence issues no memory read and answers one cycle after acceptance.
- R5: The aperture base is written at offset 0x10, bits 31:22. The slot is req_addr[31:22] minus base[31:22]. The entry read address is {slot page address, req_addr[21:12], 2'b00}. The physical address is {entry[31:12], req_addr[11:0]}.
- R6: The size code is bits 7:0 at offset 0xB4. Code 0x00 enables 64 slots, 0x20 enables 32, 0x30 enables 16, and 0x38 or any other code enables 8. A request is inside the aperture only when its slot number is below the enabled count.
- R7: A buffer miss performs exactly one memory read, and the response appears one cycle after mem_rvalid_i. A buffer hit performs no read and answers one cycle after acceptance.
- R8: The translation buffer is emptied by any write to offset 0xB8, 0x10 or 0xB4, and by a write to the control register at offset 0xB0 that sets bit 7 while it was 0. A control write that leaves bit 7 low, or that writes bit 7 high when it is already high, keeps the buffer.
- R9: From the acceptance of a request that misses until its response, req_ready_o is 0, and a memory read starts only from an accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 8 | Register offset |
| cfg_wdata_i | input | 32 | Register write data |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_addr_i | input | 32 | Aperture address to translate |
| rsp_valid_o | output | 1 | Response valid, one-cycle pulse |
| rsp_fault_o | output | 1 | Translation faulted |
| rsp_paddr_o | output | 32 | Translated physical address, zero on fault |
| mem_req_o | output | 1 | Entry read request, one-cycle pulse |
| mem_addr_o | output | 32 | Entry read byte address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Second-level entry read back |

## Verification
The assertions check properties on every cycle. A fault never carries an address. A granted translation keeps the request's low 12 bits. Memory reads are single pulses that only follow an accepted request. A flush always leaves the buffer empty, and a directory load always lands in its named slot.
Some behaviours can only be shown by the bench's scenarios. These are the correct index arithmetic against the base, the cut-off set by each size code, the hit and miss latencies counted in cycles, and which control-register sequences empty the buffer and which keep it.

// File: rtl/aper_pkg.sv
package aper_pkg;
  localparam logic [7:0] OFF_BASE = 8'h10;
  localparam logic [7:0] OFF_CTL  = 8'hB0;
  localparam logic [7:0] OFF_SIZE = 8'hB4;
  localparam logic [7:0] OFF_DIR  = 8'hB8;

  localparam int DIR_PRES_BIT = 8;
  localparam int CTL_ARM_BIT  = 7;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} xl_state_e;

  // enabled directory slots per size code
  function automatic logic [6:0] slots_of_code(input logic [7:0] code);
    case (code)
      8'h00:   return 7'd64;
      8'h20:   return 7'd32;
      8'h30:   return 7'd16;
      default: return 7'd8;
    endcase
  endfunction
endpackage

// File: rtl/aper_cfg.sv
module aper_cfg
  import aper_pkg::*;
#(
  parameter int DIR_N  = 64,
  parameter int PPN_W  = 20,
  localparam int SLOT_W = $clog2(DIR_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [7:0]        addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [SLOT_W-1:0] look_slot_i,
  output logic              look_pres_o,
  output logic [PPN_W-1:0]  look_ppn_o,
  output logic [9:0]        base_dir_o,
  output logic [6:0]        nslots_o,
  output logic              flush_o
);
  logic [DIR_N-1:0] pres_q;
  logic [PPN_W-1:0] ppn_q [DIR_N];
  logic [9:0]       base_q;
  logic [7:0]       size_q;
  logic             arm_q;

  logic dir_we, base_we, size_we, ctl_we;
  assign dir_we  = we_i && (addr_i == OFF_DIR);
  assign base_we = we_i && (addr_i == OFF_BASE);
  assign size_we = we_i && (addr_i == OFF_SIZE);
  assign ctl_we  = we_i && (addr_i == OFF_CTL);

  logic [SLOT_W-1:0] wslot;
  assign wslot = wdata_i[SLOT_W-1:0];

  // buffer flush: any mapping change, or control arm bit low->high
  assign flush_o = dir_we || base_we || size_we ||
                   (ctl_we && wdata_i[CTL_ARM_BIT] && !arm_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pres_q <= '0;
      for (int i = 0; i < DIR_N; i++) ppn_q[i] <= '0;
      base_q <= '0;
      size_q <= '0;
      arm_q  <= 1'b0;
    end else begin
      if (dir_we) begin
        pres_q[wslot] <= wdata_i[DIR_PRES_BIT];
        ppn_q[wslot]  <= wdata_i[31:32-PPN_W];
      end
      if (base_we) base_q <= wdata_i[31:22];
      if (size_we) size_q <= wdata_i[7:0];
      if (ctl_we)  arm_q  <= wdata_i[CTL_ARM_BIT];
    end
  end

  assign look_pres_o = pres_q[look_slot_i];
  assign look_ppn_o  = ppn_q[look_slot_i];
  assign base_dir_o  = base_q;
  assign nslots_o    = slots_of_code(size_q);

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[11:9], wdata_i[21:SLOT_W]};

  p_dir_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_we |=> pres_q[$past(wslot)] == $past(wdata_i[DIR_PRES_BIT]));
endmodule

// File: rtl/aper_tlb.sv
module aper_tlb #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             fill_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic [VPN_W-1:0] look_vpn_i,
  output logic             hit_o,
  output logic [PPN_W-1:0] ppn_o
);
  logic             valid_q;
  logic [VPN_W-1:0] vpn_q;
  logic [PPN_W-1:0] ppn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      vpn_q   <= '0;
      ppn_q   <= '0;
    end else if (flush_i) begin
      valid_q <= 1'b0;
    end else if (fill_i) begin
      valid_q <= 1'b1;
      vpn_q   <= fill_vpn_i;
      ppn_q   <= fill_ppn_i;
    end
  end

  assign hit_o = valid_q && (vpn_q == look_vpn_i);
  assign ppn_o = ppn_q;

  p_flush_empties_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !valid_q);
endmodule

// File: rtl/aper_xlate.sv
module aper_xlate
  import aper_pkg::*;
#(
  parameter int DIR_N = 64,
  localparam int SLOT_W = $clog2(DIR_N),
  localparam int PPN_W  = 20
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [7:0]  cfg_addr_i,
  input  logic [31:0] cfg_wdata_i,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [31:0] req_addr_i,
  output logic        rsp_valid_o,
  output logic        rsp_fault_o,
  output logic [31:0] rsp_paddr_o,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_rvalid_i,
  input  logic [31:0] mem_rdata_i
);
  xl_state_e state_q;

  logic [9:0]       base_dir;
  logic [6:0]       nslots;
  logic             flush;
  logic             dir_pres;
  logic [PPN_W-1:0] dir_ppn;
  logic             tlb_hit;
  logic [PPN_W-1:0] tlb_ppn;
  logic             tlb_fill;

  logic [9:0] vdir;
  logic       in_rng;
  logic       accept;
  assign vdir   = req_addr_i[31:22] - base_dir;
  assign in_rng = vdir < {3'b000, nslots};
  assign accept = req_valid_i && (state_q == S_IDLE);

  aper_cfg #(.DIR_N(DIR_N), .PPN_W(PPN_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i        (cfg_we_i),
    .addr_i      (cfg_addr_i),
    .wdata_i     (cfg_wdata_i),
    .look_slot_i (vdir[SLOT_W-1:0]),
    .look_pres_o (dir_pres),
    .look_ppn_o  (dir_ppn),
    .base_dir_o  (base_dir),
    .nslots_o    (nslots),
    .flush_o     (flush)
  );

  logic [31:0] vaddr_q;
  logic [31:0] maddr_q;
  logic        fill_ok_q;
  logic        rsp_valid_q, rsp_fault_q;
  logic [31:0] rsp_paddr_q;

  assign tlb_fill = (state_q == S_WAIT) && mem_rvalid_i && mem_rdata_i[0] && fill_ok_q;

  aper_tlb #(.VPN_W(20), .PPN_W(PPN_W)) u_tlb (
    .clk_i, .rst_ni,
    .flush_i    (flush),
    .fill_i     (tlb_fill),
    .fill_vpn_i (vaddr_q[31:12]),
    .fill_ppn_i (mem_rdata_i[31:12]),
    .look_vpn_i (req_addr_i[31:12]),
    .hit_o      (tlb_hit),
    .ppn_o      (tlb_ppn)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      vaddr_q     <= '0;
      maddr_q     <= '0;
      fill_ok_q   <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_paddr_q <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (flush) fill_ok_q <= 1'b0;
      case (state_q)
        S_IDLE: if (accept) begin
          vaddr_q <= req_addr_i;
          if (!in_rng || !dir_pres) begin
            rsp_valid_q <= 1'b1;
            rsp_fault_q <= 1'b1;
            rsp_paddr_q <= '0;
          end else if (tlb_hit) begin
            rsp_valid_q <= 1'b1;
            rsp_fault_q <= 1'b0;
            rsp_paddr_q <= {tlb_ppn, req_addr_i[11:0]};
          end else begin
            maddr_q   <= {dir_ppn, req_addr_i[21:12], 2'b00};
            fill_ok_q <= !flush;
            state_q   <= S_REQ;
          end
        end
        S_REQ: state_q <= S_WAIT;
        S_WAIT: if (mem_rvalid_i) begin
          rsp_valid_q <= 1'b1;
          rsp_fault_q <= !mem_rdata_i[0];
          rsp_paddr_q <= mem_rdata_i[0] ? {mem_rdata_i[31:12], vaddr_q[11:0]} : 32'h0;
          state_q     <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign mem_req_o   = (state_q == S_REQ);
  assign mem_addr_o  = maddr_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_fault_o = rsp_fault_q;
  assign rsp_paddr_o = rsp_paddr_q;

  logic unused_rdata;
  assign unused_rdata = ^mem_rdata_i[11:1];

  p_fault_no_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_paddr_o == 32'h0));
  p_offset_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |-> (rsp_paddr_o[11:0] == vaddr_q[11:0]));
  p_mem_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  p_fetch_after_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> $past(req_valid_i && req_ready_o));
  p_busy_no_rsp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (!req_ready_o && !rsp_valid_o));
endmodule

// File: tb/sim_aper_xlate.sv
module sim_aper_xlate;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_paddr;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0, n_fail = 0;
  int reads = 0, cyc = 0, rv_cyc = 0, cnt = 0;
  logic [31:0] last_maddr = '0;

  always #10 clk = ~clk;

  aper_xlate u0 (
    .clk_i(clk), .rst_ni,
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_paddr_o(rsp_paddr),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  // entry memory model: offset 0x3FF reads as unmapped
  function automatic logic [31:0] ent(input logic [31:0] a);
    if (a[11:2] == 10'h3FF) return 32'h0;
    return {a[31:12] ^ 20'hA0000 ^ {10'd0, a[11:2]}, 11'd0, 1'b1};
  endfunction

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = ent(last_maddr);
        rv_cyc     = cyc;
      end
    end
    if (mem_req) begin
      last_maddr = mem_addr;
      reads++;
      cnt = 2;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic xlate(input logic [31:0] va, input bit exp_fault, input int exp_reads,
                       input logic [31:0] exp_maddr, input string tag);
    logic [31:0] exp_pa;
    int r0, waited;
    exp_pa = exp_fault ? 32'h0 : {ent(exp_maddr)[31:12], va[11:0]};
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    r0 = reads;
    req_valid = 1'b1; req_addr = va;
    @(negedge clk);
    req_valid = 1'b0;
    waited = 1;
    if (exp_reads > 0) check(!req_ready, {tag, " R9 busy"}, 32'(req_ready), 32'h0);
    while (!rsp_valid && waited < 60) begin
      @(negedge clk);
      waited++;
    end
    check(rsp_valid, {tag, " rsp seen"}, 32'(rsp_valid), 32'h1);
    check(rsp_fault == exp_fault, {tag, " fault"}, 32'(rsp_fault), 32'(exp_fault));
    check(rsp_paddr == exp_pa, {tag, " paddr"}, rsp_paddr, exp_pa);
    check(reads - r0 == exp_reads, {tag, " reads"}, 32'(reads - r0), 32'(exp_reads));
    if (exp_reads == 0)
      check(waited == 1, {tag, " R7 latency"}, 32'(waited), 32'h1);
    else begin
      check(last_maddr == exp_maddr, {tag, " R5 maddr"}, last_maddr, exp_maddr);
      check(cyc == rv_cyc + 1, {tag, " R7 after rvalid"}, 32'(cyc), 32'(rv_cyc + 1));
    end
  endtask

  task automatic t_reset;
    check(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'h1);
    check(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'h0);
    check(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 32'h0);
  endtask

  task automatic t_basic;
    cfg_wr(8'h10, 32'h4000_0000);
    cfg_wr(8'hB4, 32'h0);
    xlate(32'h4000_1234, 1'b1, 0, 32'h0, "R1 slot absent after reset");
    cfg_wr(8'hB8, 32'h0012_3100);
    cfg_wr(8'hB8, 32'h0045_6000 | 32'h0E00 | 32'h00C0 | 32'h0100 | 32'd5);
    xlate(32'h4000_1234, 1'b0, 1, 32'h0012_3004, "R5 miss slot0");
    xlate(32'h4000_1ABC, 1'b0, 0, 32'h0012_3004, "R7 hit");
    xlate(32'h4147_0FF0, 1'b0, 1, 32'h0045_61C0, "R2 slot5 ignored bits");
  endtask

  task automatic t_faults;
    xlate(32'h40C0_0000, 1'b1, 0, 32'h0, "R4 slot absent");
    xlate(32'h3FC0_0000, 1'b1, 0, 32'h0, "R4 below base");
    xlate(32'h403F_F000, 1'b1, 1, 32'h0012_3FFC, "R4 entry invalid");
    xlate(32'h403F_F000, 1'b1, 1, 32'h0012_3FFC, "R4 invalid not cached");
  endtask

  task automatic t_sizes;
    cfg_wr(8'hB8, 32'h0078_9100 | 32'd8);
    cfg_wr(8'hB8, 32'h00AB_C100 | 32'd32);
    cfg_wr(8'hB4, 32'h38);
    xlate(32'h4200_0000, 1'b1, 0, 32'h0, "R6 code38 slot8 out");
    xlate(32'h4140_0000, 1'b0, 1, 32'h0045_6000, "R6 code38 slot5 in");
    cfg_wr(8'hB4, 32'h30);
    xlate(32'h4200_0000, 1'b0, 1, 32'h0078_9000, "R6 code30 slot8 in");
    cfg_wr(8'hB4, 32'h20);
    xlate(32'h4800_0000, 1'b1, 0, 32'h0, "R6 code20 slot32 out");
    cfg_wr(8'hB4, 32'h00);
    xlate(32'h4800_0000, 1'b0, 1, 32'h00AB_C000, "R6 code00 slot32 in");
    cfg_wr(8'hB4, 32'h11);
    xlate(32'h4200_0000, 1'b1, 0, 32'h0, "R6 other code 8 slots");
    cfg_wr(8'hB4, 32'h00);
  endtask

  task automatic t_flush;
    cfg_wr(8'hB0, 32'h2280);
    xlate(32'h4000_2000, 1'b0, 1, 32'h0012_3008, "R8 fill");
    xlate(32'h4000_2004, 1'b0, 0, 32'h0012_3008, "R8 hit");
    cfg_wr(8'hB0, 32'h2280);
    xlate(32'h4000_2008, 1'b0, 0, 32'h0012_3008, "R8 arm already high keeps");
    cfg_wr(8'hB0, 32'h2200);
    xlate(32'h4000_200C, 1'b0, 0, 32'h0012_3008, "R8 arm low keeps");
    cfg_wr(8'hB0, 32'h2280);
    xlate(32'h4000_2010, 1'b0, 1, 32'h0012_3008, "R8 arm rise flushes");
    cfg_wr(8'hB8, 32'h0055_5100 | 32'd9);
    xlate(32'h4000_2014, 1'b0, 1, 32'h0012_3008, "R8 dir write flushes");
    cfg_wr(8'h10, 32'h4000_0000);
    xlate(32'h4000_2018, 1'b0, 1, 32'h0012_3008, "R8 base write flushes");
  endtask

  task automatic t_invalidate;
    cfg_wr(8'hB8, 32'h0000_0000);
    xlate(32'h4000_2000, 1'b1, 0, 32'h0, "R3 slot0 invalidated");
    xlate(32'h4147_0000, 1'b0, 1, 32'h0045_61C0, "R3 slot5 kept");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_faults();
    t_sizes();
    t_flush();
    t_invalidate();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule